// File: doc/BRIEF.md
# Per-Line Read/Write Sharing Classifier

This block sits beside the memory controller of one node in a multi-node system and keeps a two-bit sharing class for every 128-byte line homed at that node. Every access that reaches the home memory is presented to the block with its line number, whether it reads or writes, and whether the requester is this node or another node. The block looks up the line's present class, works out the new class, stores it and reports it one cycle later. With the new class it raises a flag when the access is a write that must be followed by a broadcast invalidate to the other nodes.

Broadcasts are kept for lines that are both read and written by more than one node. A line that has become read-write shared would otherwise stay that way, so on writes to such a line a pseudo-random draw from a 16-bit LFSR can demote it. The draw is compared with a threshold input that sets how often demotion happens. A demoted line still raises the broadcast on that write, so only one valid copy remains. The per-line table is a stand-in for spare check bits stored next to the data. The requester computes the line number by dropping the seven byte-offset bits of the address.

Top module: `line_share_classifier`

## Requirements
- R1: After reset, res_valid, res_class and res_bcast are 0 and every line is uncached. The class codes are 2'b00 uncached, 2'b01 private, 2'b10 read-shared and 2'b11 read-write-shared.
- R2: A local read or a local write to an uncached line gives private (01).
- R3: A remote read to an uncached or private line gives read-shared (10). A remote read leaves read-shared and read-write-shared lines unchanged. A local read leaves private, read-shared and read-write-shared lines unchanged.
- R4: A remote write gives read-write-shared (11) from any class when no demotion is drawn.
- R5: A local write to a read-shared line gives read-write-shared. A local write to a private line leaves it private.
- R6: res_bcast is 1 exactly when the access was a write and the line's class before the access was read-write-shared. Reads never raise it.
- R7: When demotion is drawn on a write to a read-write-shared line, a local write gives private and a remote write gives read-shared, and res_bcast is still 1. Reads are never demoted.
- R8: Demotion is drawn when the current LFSR value is less than or equal to demote_thr. The LFSR is never zero, so demote_thr = 0 never demotes and demote_thr = 16'hFFFF always demotes.
- R9: res_valid, res_class and res_bcast are registered one cycle after the access. A cycle with acc_valid low gives res_valid 0 and changes no line.
- R10: Lines are independent. An access changes only the class of the line it names, and back-to-back accesses to one line each see the class left by the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 write, 0 read |
| acc_remote | input | 1 | 1 requester is another node, 0 this node |
| acc_line | input | LINE_W (6) | Line number (address without byte offset) |
| demote_thr | input | 16 | Demotion threshold compared with the LFSR |
| res_valid | output | 1 | Result of last cycle's access is present |
| res_class | output | 2 | New class of the accessed line |
| res_bcast | output | 1 | Access requires a broadcast invalidate |

## Verification
A demotion and a broadcast can fall on the same write: the write to a read-write-shared line both leaves that class and asks for the invalidate. The bench forces this by setting the threshold to all ones and writing, from the local side and then from the remote side, to lines it has already made read-write shared. It expects private or read-shared together with the flag set in the same result cycle. With the threshold at zero, the same writes must keep the class at 11 with the flag set, and a read under the all-ones threshold must show no demotion and no flag.

// File: rtl/shc_pkg.sv
package shc_pkg;

    typedef enum logic [1:0] {
        CLS_NONE = 2'b00,
        CLS_OWN  = 2'b01,
        CLS_RSH  = 2'b10,
        CLS_RWSH = 2'b11
    } share_cls_e;

    typedef struct packed {
        logic write;
        logic remote;
    } acc_kind_t;

    typedef struct packed {
        share_cls_e cls;
        logic       bcast;
    } upd_t;

    // Next class and broadcast decision for one access.
    function automatic upd_t classify(share_cls_e cur, acc_kind_t k, logic demote);
        upd_t r;
        r.cls   = cur;
        r.bcast = k.write && (cur == CLS_RWSH);
        if (cur == CLS_RWSH) begin
            if (k.write && demote) begin
                r.cls = k.remote ? CLS_RSH : CLS_OWN;
            end
        end else if (k.remote) begin
            if (k.write) begin
                r.cls = CLS_RWSH;
            end else if (cur != CLS_RSH) begin
                r.cls = CLS_RSH;
            end
        end else begin
            if (cur == CLS_NONE) begin
                r.cls = CLS_OWN;
            end else if (cur == CLS_RSH && k.write) begin
                r.cls = CLS_RWSH;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/shc_lfsr.sv
module shc_lfsr #(
    parameter int          WIDTH = 16,
    parameter logic [15:0] TAPS  = 16'hB400,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst,
    output logic [WIDTH-1:0] value
);
    localparam logic [WIDTH-1:0] TAP_V  = TAPS[WIDTH-1:0];
    localparam logic [WIDTH-1:0] SEED_V = SEED[WIDTH-1:0];

    logic [WIDTH-1:0] state;

    // Galois form; never reaches zero from a nonzero seed.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEED_V;
        end else if (state[0]) begin
            state <= (state >> 1) ^ TAP_V;
        end else begin
            state <= state >> 1;
        end
    end

    assign value = state;
endmodule

// File: rtl/shc_table.sv
module shc_table #(
    parameter int LINES  = 64,
    parameter int LINE_W = $clog2(LINES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [LINE_W-1:0]   rd_line,
    output shc_pkg::share_cls_e rd_cls,
    input  logic                wr_en,
    input  logic [LINE_W-1:0]   wr_line,
    input  shc_pkg::share_cls_e wr_cls
);
    import shc_pkg::*;

    share_cls_e ent [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                ent[i] <= CLS_NONE;
            end
        end else if (wr_en) begin
            ent[wr_line] <= wr_cls;
        end
    end

    assign rd_cls = ent[rd_line];
endmodule

// File: rtl/shc_update.sv
module shc_update (
    input  shc_pkg::share_cls_e cur_cls,
    input  shc_pkg::acc_kind_t  kind,
    input  logic                demote,
    output shc_pkg::upd_t       upd
);
    import shc_pkg::*;

    always_comb begin
        upd = classify(cur_cls, kind, demote);
    end
endmodule

// File: rtl/line_share_classifier.sv
module line_share_classifier #(
    parameter int LINES  = 64,
    parameter int LFSR_W = 16,
    parameter int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_remote,
    input  logic [LINE_W-1:0] acc_line,
    input  logic [LFSR_W-1:0] demote_thr,
    output logic              res_valid,
    output logic [1:0]        res_class,
    output logic              res_bcast
);
    import shc_pkg::*;

    logic [LFSR_W-1:0] rnd;
    share_cls_e        cur_cls;
    acc_kind_t         kind;
    upd_t              upd;
    logic              demote;

    shc_lfsr #(.WIDTH(LFSR_W)) i_lfsr (
        .clk   (clk),
        .rst   (rst),
        .value (rnd)
    );

    shc_table #(.LINES(LINES), .LINE_W(LINE_W)) i_table (
        .clk     (clk),
        .rst     (rst),
        .rd_line (acc_line),
        .rd_cls  (cur_cls),
        .wr_en   (acc_valid),
        .wr_line (acc_line),
        .wr_cls  (upd.cls)
    );

    assign kind.write  = acc_write;
    assign kind.remote = acc_remote;
    assign demote      = (rnd <= demote_thr);

    shc_update i_update (
        .cur_cls (cur_cls),
        .kind    (kind),
        .demote  (demote),
        .upd     (upd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_class <= 2'b00;
            res_bcast <= 1'b0;
        end else begin
            res_valid <= acc_valid;
            res_class <= acc_valid ? upd.cls : 2'b00;
            res_bcast <= acc_valid && upd.bcast;
        end
    end
endmodule

// File: rtl/shc_checker.sv
module shc_checker #(
    parameter int LFSR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_write,
    input logic              acc_remote,
    input logic [LFSR_W-1:0] demote_thr,
    input logic              res_valid,
    input logic [1:0]        res_class,
    input logic              res_bcast
);
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> res_valid);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (!res_valid && !res_bcast));

    a_r6_bcast_only_on_write: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write) |=> !res_bcast);

    a_r2_access_leaves_cached: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> (res_class != 2'b00));

    a_r4_remote_write_shared: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_remote) |=> res_class[1]);

    a_r8_zero_thr_keeps_rwsh: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_remote && demote_thr == '0) |=> (res_class == 2'b11));

    a_r7_local_write_not_rsh: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && !acc_remote) |=> (res_class != 2'b10));
endmodule

bind line_share_classifier shc_checker #(.LFSR_W(LFSR_W)) i_shc_checker (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_remote (acc_remote),
    .demote_thr (demote_thr),
    .res_valid  (res_valid),
    .res_class  (res_class),
    .res_bcast  (res_bcast)
);

// File: tb/test_line_share_classifier.sv
module test_line_share_classifier;
    localparam int LINE_W = 6;
    localparam int NVEC   = 17;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              acc_valid = 1'b0;
    logic              acc_write = 1'b0;
    logic              acc_remote = 1'b0;
    logic [LINE_W-1:0] acc_line = '0;
    logic [15:0]       demote_thr = 16'h0000;
    logic              res_valid;
    logic [1:0]        res_class;
    logic              res_bcast;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    line_share_classifier i_line_share_classifier (
        .clk        (clk),
        .rst        (rst),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_remote (acc_remote),
        .acc_line   (acc_line),
        .demote_thr (demote_thr),
        .res_valid  (res_valid),
        .res_class  (res_class),
        .res_bcast  (res_bcast)
    );

    // {write, remote, line[5:0], class[1:0], bcast}, threshold 0
    localparam logic [10:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 6'd3, 2'b01, 1'b0},  // R2 local read uncached
        {1'b0, 1'b1, 6'd3, 2'b10, 1'b0},  // R3 remote read private
        {1'b1, 1'b0, 6'd3, 2'b11, 1'b0},  // R5 local write read-shared
        {1'b0, 1'b0, 6'd3, 2'b11, 1'b0},  // R3 local read rwsh
        {1'b1, 1'b0, 6'd3, 2'b11, 1'b1},  // R6 local write rwsh
        {1'b1, 1'b1, 6'd3, 2'b11, 1'b1},  // R6 remote write rwsh
        {1'b0, 1'b1, 6'd3, 2'b11, 1'b0},  // R3 remote read rwsh
        {1'b0, 1'b1, 6'd5, 2'b10, 1'b0},  // R3 remote read uncached
        {1'b0, 1'b0, 6'd5, 2'b10, 1'b0},  // R3 local read read-shared
        {1'b0, 1'b1, 6'd5, 2'b10, 1'b0},  // R3 remote read read-shared
        {1'b1, 1'b1, 6'd5, 2'b11, 1'b0},  // R4 remote write read-shared
        {1'b1, 1'b0, 6'd6, 2'b01, 1'b0},  // R2 local write uncached
        {1'b0, 1'b0, 6'd6, 2'b01, 1'b0},  // R3 local read private
        {1'b1, 1'b0, 6'd6, 2'b01, 1'b0},  // R5 local write private
        {1'b1, 1'b1, 6'd6, 2'b11, 1'b0},  // R4 remote write private
        {1'b1, 1'b1, 6'd7, 2'b11, 1'b0},  // R4 remote write uncached
        {1'b0, 1'b1, 6'd8, 2'b10, 1'b0}   // R10 untouched line still uncached
    };

    task automatic check(input string req, input logic [1:0] cls, input logic bc, input logic vld);
        total++;
        if (res_class !== cls || res_bcast !== bc || res_valid !== vld) begin
            bad++;
            $display("FAIL %s: got valid=%0b class=%02b bcast=%0b, want valid=%0b class=%02b bcast=%0b",
                     req, res_valid, res_class, res_bcast, vld, cls, bc);
        end
    endtask

    // Drive at a falling edge; the result is registered at the next rising edge.
    task automatic access(input logic wr, input logic rem, input logic [LINE_W-1:0] ln,
                          input logic [15:0] thr, input string req,
                          input logic [1:0] cls, input logic bc);
        @(negedge clk);
        acc_valid  = 1'b1;
        acc_write  = wr;
        acc_remote = rem;
        acc_line   = ln;
        demote_thr = thr;
        @(negedge clk);
        acc_valid  = 1'b0;
        check(req, cls, bc, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset outputs", 2'b00, 1'b0, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            access(VEC[i][10], VEC[i][9], VEC[i][8:3], 16'h0000, "R2-R6 table", VEC[i][2:1], VEC[i][0]);
        end

        // R9: idle cycle gives no result and leaves line 3 as it was
        @(negedge clk);
        check("R9 idle no result", 2'b00, 1'b0, 1'b0);
        access(1'b0, 1'b0, 6'd3, 16'h0000, "R9 idle keeps class", 2'b11, 1'b0);

        // R10 back to back on one line
        access(1'b0, 1'b0, 6'd9, 16'h0000, "R10 first", 2'b01, 1'b0);
        access(1'b0, 1'b1, 6'd9, 16'h0000, "R10 second", 2'b10, 1'b0);

        // R7/R8: forced demotion, broadcast still raised
        access(1'b0, 1'b1, 6'd3, 16'hFFFF, "R7 read not demoted", 2'b11, 1'b0);
        access(1'b1, 1'b0, 6'd3, 16'hFFFF, "R7 local demote", 2'b01, 1'b1);
        access(1'b1, 1'b1, 6'd5, 16'hFFFF, "R7 remote demote", 2'b10, 1'b1);
        access(1'b1, 1'b1, 6'd7, 16'h0000, "R8 zero thr keeps", 2'b11, 1'b1);
        access(1'b1, 1'b1, 6'd6, 16'hFFFF, "R8 ones thr demotes", 2'b10, 1'b1);

        // R1: reset clears the table
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset again", 2'b00, 1'b0, 1'b0);
        access(1'b0, 1'b1, 6'd7, 16'h0000, "R1 line cleared", 2'b10, 1'b0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: got timeout, want completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule